// File: doc/BRIEF.md
# Inter-Thread FIFO Cell with Empty/Full Views

A single storage cell that lets software threads exchange 64-bit words through a small queue. Each access carries a view code that gives the same storage different behaviour:
- **Peek view**: reads the head entry or overwrites the newest entry, without moving the queue.
- **Tag view**: reads or writes the cell's status word.
- **Blocking push/pop view**: refuses an access it cannot complete and answers with a stall.
- **Try push/pop view**: never stalls; it returns zero on an empty cell and drops data on a full one.

A requester that stalls is recorded by thread ID in a blocked-thread mask. Any later push or pop that completes in either push/pop view while the mask is non-zero produces a one-cycle wake pulse. The pulse carries the mask as it was, and the mask is then cleared so the scheduler can retry those threads.

Requests are single-cycle. The read data and the stall flag answer the request combinationally in the cycle it is presented. State, the blocked mask and the wake pulse update at the following rising clock edge. The queue depth must be a power of two of at least 2 and no more than 512.

Top module: `fifo_cell`

## Requirements
- R1: After reset the status word shows empty=1, full=0, flag T=0, FIFO flag=1, count 0 and the depth exponent log2(DEPTH), and the blocked mask is zero.
- R2: A tag-view read (view 1) returns a status word with these fields and all other bits zero:
  - bits [31:28]: the depth exponent
  - bits starting at 18: the entry count
  - bit 17: the FIFO flag, always 1
  - bit 16: T
  - bit 1: full
  - bit 0: empty
- R3: A tag-view write loads T from bit 16, empty from bit 0 and full from bit 1. When the written empty bit is 1 the entry count becomes zero.
- R4: A completed pop (view 2 or 3, read) first clears full. If the count is non-zero it returns the oldest entry, removes it and decrements the count. If the count is zero it returns 0. Empty is set whenever the count ends at zero. Order is first-in first-out across wrap-around.
- R5: A completed push (view 2 or 3, write) first clears empty. If the count is below DEPTH it appends the data and increments the count. Full is set when the count ends equal to DEPTH.
- R6: A blocking pop (view 2) while empty is set, or a blocking push (view 2) while full is set, raises stall_o. It returns 0 and leaves the count and entries unchanged. It still clears full (pop) or empty (push). It sets bit tid_i of the blocked mask.
- R7: A try pop (view 3) on an empty cell returns 0 without stalling. A try push (view 3) on a full cell does not stall and drops the data.
- R8: A peek read (view 0) returns the oldest entry without removing it.
- R9: A peek write (view 0) replaces the newest entry when the count is non-zero and has no effect when the count is zero.
- R10: A completed push or pop while the blocked mask is non-zero makes wake_o high for exactly the next cycle, with wake_mask_o equal to the mask before the access. The mask becomes zero. wake_mask_o is zero when wake_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| view_i | input | 2 | 0 peek, 1 tag, 2 blocking push/pop, 3 try push/pop |
| tid_i | input | TID_W | ID of the requesting thread |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read response, zero for writes and idle cycles |
| stall_o | output | 1 | Request could not complete and was recorded |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_mask_o | output | THREADS | Threads to wake, valid with wake_o |
| blocked_o | output | THREADS | Current blocked-thread mask |

## Verification
Several properties are checked on every cycle:
- the count never exceeds the depth;
- a stall leaves the count untouched and records the thread;
- draining the last entry raises empty, and filling the last slot raises full;
- a wake pulse lasts one cycle, carries a non-zero mask and leaves the mask cleared.

Only the bench scenarios can show that data comes out in order across index wrap-around. The same holds for peek-write overwrite targeting the newest entry, tag writes clearing the count, and try accesses dropping or returning zero. Those scenarios are compared against a queue-based model on every request.

// File: rtl/fifo_cell_pkg.sv
package fifo_cell_pkg;
  typedef enum logic [1:0] {
    VIEW_PEEK = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_TRY  = 2'd3
  } view_e;

  localparam int unsigned DATA_W    = 64;
  localparam int unsigned BIT_E     = 0;
  localparam int unsigned BIT_F     = 1;
  localparam int unsigned BIT_T     = 16;
  localparam int unsigned BIT_FIFO  = 17;
  localparam int unsigned BIT_CNT   = 18;
  localparam int unsigned BIT_DEPTH = 28;
endpackage

// File: rtl/cell_store.sv
module cell_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/cell_tag.sv
module cell_tag
  import fifo_cell_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  view_e            view_i,
  input  logic             t_wr_i,
  input  logic             e_wr_i,
  input  logic             f_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             t_o,
  output logic             e_o,
  output logic             f_o,
  output logic             mem_we_o,
  output logic [IDX_W-1:0] mem_waddr_o,
  output logic             stall_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] rd_q;
  logic t_q, e_q, f_q;
  logic ef, blk, rd_op, wr_op, pop, push, byp_wr, ctl_wr, stall;

  assign ef     = req_i && (view_i == VIEW_WAIT || view_i == VIEW_TRY);
  assign blk    = (view_i == VIEW_WAIT);
  assign rd_op  = ef && !we_i;
  assign wr_op  = ef && we_i;
  assign stall  = (rd_op && blk && e_q) || (wr_op && blk && f_q);
  assign pop    = rd_op && !stall && (cnt_q != '0);
  assign push   = wr_op && !stall && (cnt_q != FULL_CNT);
  assign byp_wr = req_i && we_i && (view_i == VIEW_PEEK) && (cnt_q != '0);
  assign ctl_wr = req_i && we_i && (view_i == VIEW_TAG);

  assign mem_we_o    = push || byp_wr;
  assign mem_waddr_o = push ? rd_q + cnt_q[IDX_W-1:0]
                            : rd_q + cnt_q[IDX_W-1:0] - IDX_W'(1);
  assign stall_o  = stall;
  assign done_o   = ef && !stall;
  assign cnt_o    = cnt_q;
  assign rd_idx_o = rd_q;
  assign t_o = t_q;
  assign e_o = e_q;
  assign f_o = f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= '0;
      t_q   <= 1'b0;
      e_q   <= 1'b1;
      f_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        t_q <= t_wr_i;
        e_q <= e_wr_i;
        f_q <= f_wr_i;
        if (e_wr_i) cnt_q <= '0;
      end
      if (rd_op) begin
        f_q <= 1'b0;
        if (pop) begin
          rd_q  <= rd_q + IDX_W'(1);
          cnt_q <= cnt_q - CNT_W'(1);
        end
        if (!stall && (cnt_q == '0 || (pop && cnt_q == CNT_W'(1)))) e_q <= 1'b1;
      end
      if (wr_op) begin
        e_q <= 1'b0;
        if (push) cnt_q <= cnt_q + CNT_W'(1);
        if (!stall && (cnt_q == FULL_CNT || (push && cnt_q == FULL_CNT - CNT_W'(1))))
          f_q <= 1'b1;
      end
    end
  end

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r6_stall_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(cnt_q));
  a_r4_drain_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && cnt_q == CNT_W'(1)) |=> e_q);
  a_r5_fill_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && cnt_q == FULL_CNT - CNT_W'(1)) |=> f_q);
endmodule

// File: rtl/cell_waiter.sv
module cell_waiter #(
  parameter int unsigned THREADS = 8,
  localparam int unsigned TID_W = $clog2(THREADS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic [TID_W-1:0]   tid_i,
  input  logic               done_i,
  output logic [THREADS-1:0] blocked_o,
  output logic               wake_o,
  output logic [THREADS-1:0] wake_mask_o
);
  logic [THREADS-1:0] blk_q, wmask_q;
  logic wake_q, fire;

  assign fire = done_i && (blk_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      wmask_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      wake_q  <= fire;
      wmask_q <= fire ? blk_q : '0;
      if (stall_i) blk_q <= blk_q | (THREADS'(1) << tid_i);
      else if (fire) blk_q <= '0;
    end
  end

  assign blocked_o   = blk_q;
  assign wake_o      = wake_q;
  assign wake_mask_o = wmask_q;

  a_r6_stall_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> blk_q[$past(tid_i)]);
  a_r10_wake_clears_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> (blk_q == '0 && wmask_q != '0));
  a_r10_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
endmodule

// File: rtl/fifo_cell.sv
module fifo_cell
  import fifo_cell_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned THREADS = 8,
  localparam int unsigned TID_W  = $clog2(THREADS),
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         view_i,
  input  logic [TID_W-1:0]   tid_i,
  input  logic [63:0]        wdata_i,
  output logic [63:0]        rdata_o,
  output logic               stall_o,
  output logic               wake_o,
  output logic [THREADS-1:0] wake_mask_o,
  output logic [THREADS-1:0] blocked_o
);
  view_e view;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rd_idx, waddr;
  logic t, e, f, mem_we, stall, done;
  logic [63:0] head, ctl_word;

  assign view = view_e'(view_i);

  cell_tag #(.DEPTH(DEPTH)) u_tag (
    .clk_i, .rst_ni, .req_i, .we_i, .view_i(view),
    .t_wr_i(wdata_i[BIT_T]), .e_wr_i(wdata_i[BIT_E]), .f_wr_i(wdata_i[BIT_F]),
    .cnt_o(cnt), .rd_idx_o(rd_idx), .t_o(t), .e_o(e), .f_o(f),
    .mem_we_o(mem_we), .mem_waddr_o(waddr), .stall_o(stall), .done_o(done)
  );

  cell_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
    .clk_i, .wr_en_i(mem_we), .wr_addr_i(waddr), .wr_data_i(wdata_i),
    .rd_addr_i(rd_idx), .rd_data_o(head)
  );

  cell_waiter #(.THREADS(THREADS)) u_wait (
    .clk_i, .rst_ni, .stall_i(stall), .tid_i, .done_i(done),
    .blocked_o, .wake_o, .wake_mask_o
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[BIT_DEPTH +: 4]   = 4'(IDX_W);
    ctl_word[BIT_CNT +: CNT_W] = cnt;
    ctl_word[BIT_FIFO] = 1'b1;
    ctl_word[BIT_T]    = t;
    ctl_word[BIT_F]    = f;
    ctl_word[BIT_E]    = e;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (view)
        VIEW_PEEK: rdata_o = head;
        VIEW_TAG:  rdata_o = ctl_word;
        default:   if (!stall && cnt != '0) rdata_o = head;
      endcase
    end
  end

  assign stall_o = stall;
endmodule

// File: tb/fifo_cell_tb_top.sv
`timescale 1ns/1ps
module fifo_cell_tb_top;
  localparam int DEPTH = 8;
  localparam int THREADS = 8;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [1:0] view = 0;
  logic [2:0] tid = 0;
  logic [63:0] wdata = 0, rdata;
  logic stall, wake;
  logic [7:0] wmask, blocked;

  fifo_cell #(.DEPTH(DEPTH), .THREADS(THREADS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .view_i(view),
    .tid_i(tid), .wdata_i(wdata), .rdata_o(rdata), .stall_o(stall),
    .wake_o(wake), .wake_mask_o(wmask), .blocked_o(blocked)
  );

  always #2.5 clk = ~clk;

  logic [63:0] q[$];
  bit m_t = 0, m_e = 1, m_f = 0;
  logic [7:0] m_blk = 0;
  int checks = 0, errors = 0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] ctl_model();
    logic [63:0] r = '0;
    r[31:28] = 4'd3;
    r[21:18] = 4'(q.size());
    r[17] = 1'b1;
    r[16] = m_t;
    r[1]  = m_f;
    r[0]  = m_e;
    return r;
  endfunction

  task automatic op(input int v, input bit w, input int t_id, input logic [63:0] d, input string rq);
    logic [63:0] er;
    bit es, known, done, ew;
    logic [7:0] em;
    er = 0; es = 0; known = 1; done = 0;
    @(negedge clk);
    req = 1; we = w; view = 2'(v); tid = 3'(t_id); wdata = d;
    #1;
    case (v)
      0: if (!w) begin
           if (q.size() > 0) er = q[0]; else known = 0;
         end else if (q.size() > 0) q[q.size()-1] = d;
      1: if (!w) er = ctl_model();
         else begin
           m_t = d[16]; m_e = d[0]; m_f = d[1];
           if (m_e) q.delete();
         end
      default: if (!w) begin
           m_f = 0;
           if (v == 2 && m_e) es = 1;
           else begin
             done = 1;
             if (q.size() > 0) er = q.pop_front();
             if (q.size() == 0) m_e = 1;
           end
         end else begin
           m_e = 0;
           if (v == 2 && m_f) es = 1;
           else begin
             done = 1;
             if (q.size() < DEPTH) q.push_back(d);
             if (q.size() == DEPTH) m_f = 1;
           end
         end
    endcase
    if (known) chk({rq, " rdata"}, rdata, er);
    chk({rq, " stall"}, 64'(stall), 64'(es));
    ew = done && (m_blk != 0);
    em = ew ? m_blk : 8'h0;
    if (es) m_blk = m_blk | (8'h1 << t_id);
    else if (ew) m_blk = 0;
    @(posedge clk); #1;
    req = 0;
    chk("R10 wake", 64'(wake), 64'(ew));
    chk("R10 wake_mask", 64'(wmask), 64'(em));
    chk({rq, " blocked"}, 64'(blocked), 64'(m_blk));
  endtask

  task automatic ctl_rd(string rq);
    op(1, 0, 0, 0, rq);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 blocked", 64'(blocked), 64'h0);
    ctl_rd("R1");                     // reset status word, layout per R2
    op(3, 0, 0, 0, "R7");             // try pop empty
    op(2, 0, 3, 0, "R6");             // blocking pop empty stalls
    op(2, 0, 5, 0, "R6");
    op(3, 1, 0, 64'h11, "R10");       // push wakes threads 3 and 5
    for (int i = 0; i < 7; i++) op(2, 1, 0, 64'hA0 + i, "R5");
    ctl_rd("R2");                     // full
    op(2, 1, 1, 64'hBAD, "R6");       // blocking push full stalls
    op(3, 1, 0, 64'hDEAD, "R7");      // try push full drops, wakes thread 1
    op(0, 0, 0, 0, "R8");             // peek
    op(0, 0, 0, 0, "R8");
    op(0, 1, 0, 64'h77, "R9");        // overwrite newest
    for (int i = 0; i < 8; i++) op((i % 2) ? 3 : 2, 0, 0, 0, "R4");
    ctl_rd("R4");
    for (int i = 0; i < 5; i++) op(2, 1, 0, 64'hC0 + i, "R5");
    for (int i = 0; i < 3; i++) op(3, 0, 0, 0, "R4");
    for (int i = 0; i < 5; i++) op(3, 1, 0, 64'hD0 + i, "R5");
    ctl_rd("R4");
    for (int i = 0; i < 7; i++) op(2, 0, 0, 0, "R4");  // wrap-around order
    op(0, 1, 0, 64'h99, "R9");        // peek write on empty ignored
    ctl_rd("R9");
    op(2, 1, 0, 64'hE1, "R9");
    op(0, 0, 0, 0, "R9");
    op(2, 1, 0, 64'hE2, "R3");
    op(1, 1, 0, 64'h10001, "R3");     // T=1, empty=1 clears count
    ctl_rd("R3");
    op(1, 1, 0, 64'h2, "R3");         // full=1, empty=0
    ctl_rd("R3");
    op(2, 1, 2, 64'h5, "R3");         // stalls because full flag set
    op(3, 0, 0, 0, "R4");             // clears full, returns 0, wakes thread 2
    ctl_rd("R4");
    op(2, 0, 4, 0, "R6");
    op(2, 1, 0, 64'hF0, "R10");
    op(2, 0, 0, 0, "R4");
    ctl_rd("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule